// File: doc/BRIEF.md
# PLL Configuration Bank Selector

This block keeps four alternative configuration sets for each of three PLLs. Each set holds a pre-divider value, a feedback multiplier value and a loop-filter code. For every PLL the block presents the contents of one set, the active set, on its outputs. A pair of general-purpose select pins picks the active set for each PLL. The pins pass through a two-flop synchronizer and a stability qualifier before they can change a selection.

After power-on reset the block always samples the pins once and captures one selection per PLL, whatever the mode input says. After that capture, the `manual_en` input decides what the pins do. When it is high, a stable change on a pin pair moves that PLL to another set during operation. When it is low, the selections stay fixed and the pins are ignored.

Configuration words reach the block through a valid/ready write port. A write names a PLL and a field, and it always lands in the set that PLL has active at that moment. The port applies back-pressure only during the start-up capture window. `wr_ready` is low from reset until every PLL has captured its first selection, and it stays high after that. A write counts as accepted only on a clock edge where `wr_valid` and `wr_ready` are both high. A source that raises `wr_valid` while `wr_ready` is low must hold the write until `wr_ready` rises; the block does not store it.

Top module: `pll_cfg_select`

## Requirements
- R1: After reset, set s of PLL p holds pre-divider s+1, multiplier 32*(p+1)+s and loop-filter code 16*p+s.
- R2: The set index for PLL p is the pin pair gin[2p+1:2p], with gin[2p] as bit 0. The active index is shown on act_sel[2p+1:2p].
- R3: wr_ready is low during reset and in the first cycle after reset is released. It goes high within 6 cycles with every selection captured from the pins, whatever the value of manual_en, and then stays high until the next reset.
- R4: With manual_en high, a pin pair that holds a new value for at least 2 cycles moves its PLL to that set within 6 cycles.
- R5: A change on a pin pair that lasts a single cycle does not alter any selection.
- R6: With manual_en low after the start-up capture, act_sel does not change, whatever the pins do.
- R7: An accepted write changes only the field it names, only in the set that is active for the addressed PLL. The new value appears on the outputs in the cycle after the accepting edge, and the other sets keep their contents.
- R8: Field code 0 selects the pre-divider (wr_data[7:0]), 1 the multiplier (wr_data[11:0]) and 2 the loop-filter code (wr_data[7:0]). Field code 3, and a PLL index of 3 or more, change nothing.
- R9: pll_off[p] is high exactly when the active pre-divider of PLL p is zero.
- R10: A write presented while wr_ready is low is dropped and leaves every set unchanged.
- R11: A change on the pins of one PLL leaves the selection of the other PLLs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous assert |
| gin | input | 6 | Select pins, two per PLL |
| manual_en | input | 1 | High: pins steer the selections live |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write port can accept |
| wr_pll | input | 2 | Target PLL index |
| wr_field | input | 2 | Field code: 0 pre-divider, 1 multiplier, 2 loop filter |
| wr_data | input | 12 | Write value |
| act_sel | output | 6 | Active set index per PLL |
| act_pdiv | output | 24 | Active pre-divider per PLL, 8 bits each |
| act_mult | output | 36 | Active multiplier per PLL, 12 bits each |
| act_lf | output | 24 | Active loop-filter code per PLL, 8 bits each |
| pll_off | output | 3 | Active pre-divider of that PLL is zero |

## Verification
The bench uses the default parameters: three PLLs, four sets each, and a two-cycle stability window. With four sets, every pin pair value maps to a real set, so random pin patterns can reach all twelve sets and can expose a write that lands in the wrong one. With a two-cycle window, a one-cycle pin pulse is the smallest change that must be rejected and a two-cycle hold the smallest that must be accepted. Since a PLL index of 3 addresses no PLL, the 2-bit index field also lets the bench drive a write that must be dropped.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  localparam int PDIV_W = 8;
  localparam int MULT_W = 12;
  localparam int LF_W   = 8;
  localparam int DATA_W = MULT_W;

  typedef enum logic [1:0] {
    FLD_PDIV = 2'd0,
    FLD_MULT = 2'd1,
    FLD_LF   = 2'd2,
    FLD_NONE = 2'd3
  } fld_e;

  typedef struct packed {
    logic [PDIV_W-1:0] pdiv;
    logic [MULT_W-1:0] mult;
    logic [LF_W-1:0]   lf;
  } cfg_t;

  // Power-on contents of set s for PLL p
  function automatic cfg_t cfg_default(input int pll, input int set);
    cfg_t c;
    c.pdiv = PDIV_W'(set + 1);
    c.mult = MULT_W'(32 * (pll + 1) + set);
    c.lf   = LF_W'(16 * pll + set);
    return c;
  endfunction
endpackage

// File: rtl/pll_cfg_sync.sv
// Multi-stage synchronizer with a valid flag that rises once the chain is flushed
module pll_cfg_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         dvld
);
  logic [W-1:0]      stg_q [STAGES];
  logic [STAGES-1:0] vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      vld_q <= '0;
    end else begin
      stg_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      vld_q <= {vld_q[STAGES-2:0], 1'b1};
    end
  end

  assign dout = stg_q[STAGES-1];
  assign dvld = vld_q[STAGES-1];
endmodule

// File: rtl/pll_cfg_qual.sv
// Stability qualifier and selection register for one PLL
module pll_cfg_qual #(
  parameter int SEL_W      = 2,
  parameter int STABLE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] pin_sync,
  input  logic             pin_vld,
  input  logic             manual_en,
  output logic [SEL_W-1:0] sel,
  output logic             captured
);
  localparam int CNT_W = (STABLE_CYC > 2) ? $clog2(STABLE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(STABLE_CYC - 1);

  logic [SEL_W-1:0] prev_q, sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cap_q;
  logic             steady;

  assign steady = (cnt_q == CNT_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      cnt_q  <= '0;
      sel_q  <= '0;
      cap_q  <= 1'b0;
    end else begin
      prev_q <= pin_sync;
      if (!pin_vld || (pin_sync != prev_q)) cnt_q <= '0;
      else if (!steady)                     cnt_q <= cnt_q + 1'b1;
      // first qualified value is always taken; later ones only in manual mode
      if (steady && (!cap_q || manual_en)) begin
        sel_q <= prev_q;
        cap_q <= 1'b1;
      end
    end
  end

  assign sel      = sel_q;
  assign captured = cap_q;
endmodule

// File: rtl/pll_cfg_bank.sv
// Configuration sets of one PLL; writes go to the active set
module pll_cfg_bank
  import pll_cfg_pkg::*;
#(
  parameter int NUM_SET = 4,
  parameter int SEL_W   = 2,
  parameter int PLL_ID  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel,
  input  logic              wr_en,
  input  fld_e              wr_fld,
  input  logic [DATA_W-1:0] wr_data,
  output cfg_t              act
);
  cfg_t mem_q [NUM_SET];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SET; s++) mem_q[s] <= cfg_default(PLL_ID, s);
    end else if (wr_en) begin
      case (wr_fld)
        FLD_PDIV: mem_q[sel].pdiv <= wr_data[PDIV_W-1:0];
        FLD_MULT: mem_q[sel].mult <= wr_data[MULT_W-1:0];
        FLD_LF:   mem_q[sel].lf   <= wr_data[LF_W-1:0];
        default:  ;
      endcase
    end
  end

  assign act = mem_q[sel];
endmodule

// File: rtl/pll_cfg_select.sv
module pll_cfg_select
  import pll_cfg_pkg::*;
#(
  parameter int NUM_PLL     = 3,
  parameter int NUM_SET     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CYC  = 2,
  localparam int SEL_W  = $clog2(NUM_SET),
  localparam int GIN_W  = NUM_PLL * SEL_W,
  localparam int PIDX_W = (NUM_PLL > 2) ? $clog2(NUM_PLL + 1) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [GIN_W-1:0]          gin,
  input  logic                      manual_en,
  input  logic                      wr_valid,
  output logic                      wr_ready,
  input  logic [PIDX_W-1:0]         wr_pll,
  input  logic [1:0]                wr_field,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [GIN_W-1:0]          act_sel,
  output logic [NUM_PLL*PDIV_W-1:0] act_pdiv,
  output logic [NUM_PLL*MULT_W-1:0] act_mult,
  output logic [NUM_PLL*LF_W-1:0]   act_lf,
  output logic [NUM_PLL-1:0]        pll_off
);
  logic [GIN_W-1:0]   gin_s;
  logic               gin_vld;
  logic [NUM_PLL-1:0] cap;
  logic               wr_go;

  pll_cfg_sync #(.W(GIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(gin), .dout(gin_s), .dvld(gin_vld)
  );

  assign wr_ready = &cap;
  assign wr_go    = wr_valid && wr_ready;

  for (genvar p = 0; p < NUM_PLL; p++) begin : g_pll
    logic [SEL_W-1:0] sel;
    cfg_t             act;

    pll_cfg_qual #(.SEL_W(SEL_W), .STABLE_CYC(STABLE_CYC)) u_qual (
      .clk(clk), .rst_n(rst_n),
      .pin_sync(gin_s[p*SEL_W +: SEL_W]), .pin_vld(gin_vld),
      .manual_en(manual_en), .sel(sel), .captured(cap[p])
    );

    pll_cfg_bank #(.NUM_SET(NUM_SET), .SEL_W(SEL_W), .PLL_ID(p)) u_bank (
      .clk(clk), .rst_n(rst_n), .sel(sel),
      .wr_en(wr_go && (wr_pll == PIDX_W'(p))),
      .wr_fld(fld_e'(wr_field)), .wr_data(wr_data), .act(act)
    );

    assign act_sel[p*SEL_W +: SEL_W]    = sel;
    assign act_pdiv[p*PDIV_W +: PDIV_W] = act.pdiv;
    assign act_mult[p*MULT_W +: MULT_W] = act.mult;
    assign act_lf[p*LF_W +: LF_W]       = act.lf;
    assign pll_off[p]                   = (act.pdiv == '0);
  end
endmodule

// File: rtl/pll_cfg_select_chk.sv
module pll_cfg_select_chk
  import pll_cfg_pkg::*;
#(
  parameter int NUM_PLL = 3,
  parameter int NUM_SET = 4,
  localparam int SEL_W  = $clog2(NUM_SET),
  localparam int GIN_W  = NUM_PLL * SEL_W,
  localparam int PIDX_W = (NUM_PLL > 2) ? $clog2(NUM_PLL + 1) : 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [GIN_W-1:0]          gin,
  input logic                      manual_en,
  input logic                      wr_valid,
  input logic                      wr_ready,
  input logic [PIDX_W-1:0]         wr_pll,
  input logic [1:0]                wr_field,
  input logic [DATA_W-1:0]         wr_data,
  input logic [GIN_W-1:0]          act_sel,
  input logic [NUM_PLL*PDIV_W-1:0] act_pdiv,
  input logic [NUM_PLL*MULT_W-1:0] act_mult,
  input logic [NUM_PLL*LF_W-1:0]   act_lf,
  input logic [NUM_PLL-1:0]        pll_off
);
  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |=> wr_ready); // R3

  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && !manual_en) |=> $stable(act_sel)); // R6

  AST_SEL_NEEDS_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_ready) && !$stable(act_sel)) |-> $past(manual_en)); // R4

  AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |=> (wr_ready || ($stable(act_pdiv) && $stable(act_mult) && $stable(act_lf)))); // R10

  AST_PDIV_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !manual_en && wr_pll == '0 && wr_field == 2'd0)
    |=> (act_pdiv[PDIV_W-1:0] == $past(wr_data[PDIV_W-1:0]))); // R7
endmodule

bind pll_cfg_select pll_cfg_select_chk #(.NUM_PLL(NUM_PLL), .NUM_SET(NUM_SET)) u_chk (.*);

// File: tb/pll_cfg_select_test.sv
module pll_cfg_select_test;
  localparam int NP = 3;
  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  gin = '0;
  logic        manual_en = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [1:0]  wr_pll = '0;
  logic [1:0]  wr_field = '0;
  logic [11:0] wr_data = '0;
  logic [5:0]  act_sel;
  logic [23:0] act_pdiv;
  logic [35:0] act_mult;
  logic [23:0] act_lf;
  logic [2:0]  pll_off;

  always #4 clk = ~clk;

  pll_cfg_select uut (
    .clk(clk), .rst_n(rst_n), .gin(gin), .manual_en(manual_en),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_pll(wr_pll),
    .wr_field(wr_field), .wr_data(wr_data), .act_sel(act_sel),
    .act_pdiv(act_pdiv), .act_mult(act_mult), .act_lf(act_lf), .pll_off(pll_off)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int e_pdiv [NP][NS];
  int e_mult [NP][NS];
  int e_lf   [NP][NS];
  int e_sel  [NP];

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R1 defaults, R2 pin mapping
  task automatic model_reset();
    for (int p = 0; p < NP; p++) begin
      for (int s = 0; s < NS; s++) begin
        e_pdiv[p][s] = s + 1;
        e_mult[p][s] = 32 * (p + 1) + s;
        e_lf[p][s]   = 16 * p + s;
      end
      e_sel[p] = int'(gin[p*2 +: 2]);
    end
  endtask

  task automatic check_all(input string req);
    for (int p = 0; p < NP; p++) begin
      chk(req, $sformatf("sel%0d", p), int'(act_sel[p*2 +: 2]), e_sel[p]);
      chk(req, $sformatf("pdiv%0d", p), int'(act_pdiv[p*8 +: 8]), e_pdiv[p][e_sel[p]]);
      chk(req, $sformatf("mult%0d", p), int'(act_mult[p*12 +: 12]), e_mult[p][e_sel[p]]);
      chk(req, $sformatf("lf%0d", p), int'(act_lf[p*8 +: 8]), e_lf[p][e_sel[p]]);
      chk(req, $sformatf("off%0d", p), int'(pll_off[p]), (e_pdiv[p][e_sel[p]] == 0) ? 1 : 0);
    end
  endtask

  // R7, R8: model of a write accepted by a ready port
  task automatic do_write(input int p, input int f, input int d);
    wr_pll = 2'(p); wr_field = 2'(f); wr_data = 12'(d); wr_valid = 1'b1;
    tick(1);
    wr_valid = 1'b0;
    if (p < NP) begin
      case (f)
        0: e_pdiv[p][e_sel[p]] = d & 'hFF;
        1: e_mult[p][e_sel[p]] = d & 'hFFF;
        2: e_lf[p][e_sel[p]]   = d & 'hFF;
        default: ;
      endcase
    end
  endtask

  task automatic set_pins(input logic [5:0] g, input bit m);
    gin = g; manual_en = m;
    tick(8);
    if (m) for (int p = 0; p < NP; p++) e_sel[p] = int'(g[p*2 +: 2]);
  endtask

  task automatic glitch(input logic [5:0] mask);
    gin = gin ^ mask;
    tick(1);
    gin = gin ^ mask;
    tick(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7731));
    gin = 6'b10_01_11; manual_en = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R3", "ready_early", int'(wr_ready), 0);
    tick(7);
    chk("R3", "ready_late", int'(wr_ready), 1);
    model_reset();
    check_all("R1 R2 R3");

    set_pins(6'b00_11_00, 1'b0);
    check_all("R6");

    do_write(0, 0, 'h5A);
    do_write(0, 1, 'hABC);
    do_write(0, 2, 'h33);
    check_all("R7");
    set_pins(6'b10_01_00, 1'b1);
    check_all("R7 R11");
    set_pins(6'b10_01_11, 1'b1);
    check_all("R7");

    do_write(0, 3, 'hFFF);
    do_write(3, 0, 'h77);
    check_all("R8");

    do_write(1, 0, 0);
    chk("R9", "off1", int'(pll_off[1]), 1);
    check_all("R9");

    glitch(6'b000011);
    check_all("R5");
    glitch(6'b110000);
    check_all("R5");

    set_pins(6'b11_10_11, 1'b1);
    check_all("R11");
    set_pins(gin ^ 6'b010101, 1'b1);
    check_all("R4");

    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom % 4);
      if (op < 2) do_write(int'($urandom % 4), int'($urandom % 4), int'($urandom % 4096));
      else if (op == 2) set_pins(6'($urandom), bit'($urandom % 2));
      else glitch(6'(1 << ($urandom % 6)));
      check_all("R4 R5 R6 R7 R8 random");
    end

    // R10: write during the start-up window is dropped
    gin = 6'($urandom); manual_en = 1'b0;
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    wr_pll = 2'd0; wr_field = 2'd1; wr_data = 12'h000; wr_valid = 1'b1;
    tick(1);
    chk("R10", "ready_busy", int'(wr_ready), 0);
    wr_valid = 1'b0;
    tick(8);
    model_reset();
    check_all("R10 R1");

    finish_run();
  end
endmodule